// File: doc/BRIEF.md
# Machine-Mode CSR Permission Guard

This block sits beside the CSR unit of a small RISC-V hart and rules on every CSR instruction: is the access legal, or does it raise an illegal-instruction exception? For each valid instruction it receives the 12-bit CSR address, a read strobe, a write strobe, the debug-mode state of the hart, the instruction PC and the write data. These are captured in one stage register. The illegal flag is then formed combinationally from the captured values.

Permission depends on both the class of the address and the direction of the access. Identification registers, the trigger selector and two custom interrupt-status registers may be read but not written. Debug registers are reachable only while the hart is in debug mode. Unimplemented addresses trap in both directions. On a trap, the cause register takes the illegal-instruction code and the exception PC register takes the faulting PC, one clock after the flag is raised. Any write side effect is dropped. A handful of writable registers are kept so that legal writes can be shown to persist. The upstream decoder drives the strobes, so a read-only form of a set/clear instruction with a zero source arrives with the write strobe low.

Top module: `csr_guard`

## Requirements
- R1: Addresses 0xF11 to 0xF15 are legal to read and trap on write. A read of 0xF14 returns the HART_ID parameter (default 5).
- R2: Addresses 0x302 and 0x303 trap on both read and write.
- R3: Address 0x7A0 is legal to read and traps on write. Address 0x7A1 traps on both read and write.
- R4: Addresses 0x7B0 to 0x7B3 and 0xBFF trap on any access while the debug input is low, and are legal while it is high. A value written to 0x7B2 in debug mode reads back in debug mode.
- R5: Addresses 0xFE0 and 0xFE4 are legal to read and trap on write. Address 0xBE0 is read/write, and a value written to it reads back.
- R6: These addresses are legal for both read and write: 0x300, 0x301, 0x304, 0x305, 0x310, 0x320, 0x323, 0x340 to 0x344, 0xB00, 0xB02 to 0xB1F, 0xB80 and 0xB82 to 0xB9F. Values written to 0x305, 0x340, 0x341 and 0x342 read back.
- R7: Any address not named in R1 to R6 traps on both read and write (0x7A2 and 0xB01 are examples).
- R8: On the clock edge after a trapping instruction is flagged, the cause output becomes 2 and the exception-PC output becomes that instruction's PC.
- R9: A trapping access changes no stored register. The illegal flag stays low when no valid instruction is captured, or when a valid instruction asserts neither strobe.
- R10: After synchronous reset, the illegal flag, read data, cause and exception PC are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | A CSR instruction is presented this cycle |
| csr_addr | input | 12 | CSR address field of the instruction |
| rd_en | input | 1 | Instruction reads the CSR |
| wr_en | input | 1 | Instruction writes the CSR |
| dbg_mode | input | 1 | Hart is in debug mode |
| ins_pc | input | 32 | PC of the instruction |
| wr_data | input | 32 | Data to write |
| illegal | output | 1 | Captured access must raise illegal-instruction |
| rd_data | output | 32 | Read value of the captured legal read, else zero |
| cause_q | output | 32 | Exception cause register |
| epc_q | output | 32 | Exception PC register |

## Verification
A misclassified address appears on the illegal output in the first cycle after the instruction is captured. The table walk checks every address class in both directions, and in both debug states where the debug state matters. If the cause or PC capture is broken, the error shows on the cause and exception-PC ports one edge after the flag. A leaked write from a trapping access stays hidden until that register is next read. The bench therefore reads the register back in a legal mode straight after each suppressed write.

// File: rtl/csr_guard_pkg.sv
package csr_guard_pkg;
  typedef enum logic [1:0] {
    ACC_ABSENT,
    ACC_RO,
    ACC_RW,
    ACC_DBG
  } acc_class_e;

  localparam logic [11:0] A_HARTID   = 12'hF14;
  localparam logic [11:0] A_MTVEC    = 12'h305;
  localparam logic [11:0] A_MSCRATCH = 12'h340;
  localparam logic [11:0] A_MEPC     = 12'h341;
  localparam logic [11:0] A_MCAUSE   = 12'h342;
  localparam logic [11:0] A_IRQ_EN   = 12'hBE0;
  localparam logic [11:0] A_DSCR0    = 12'h7B2;
  localparam logic [11:0] A_DSCR1    = 12'h7B3;

  function automatic acc_class_e classify(input logic [11:0] a);
    acc_class_e c;
    c = ACC_ABSENT;
    if (a >= 12'hF11 && a <= 12'hF15) c = ACC_RO;
    else if (a == 12'h7A0 || a == 12'hFE0 || a == 12'hFE4) c = ACC_RO;
    else if ((a >= 12'h7B0 && a <= 12'h7B3) || a == 12'hBFF) c = ACC_DBG;
    else if (a == 12'h300 || a == 12'h301 || a == 12'h304 || a == 12'h305 ||
             a == 12'h310 || a == 12'h320 || a == 12'h323 || a == A_IRQ_EN) c = ACC_RW;
    else if (a >= 12'h340 && a <= 12'h344) c = ACC_RW;
    else if (a == 12'hB00 || a == 12'hB80) c = ACC_RW;
    else if ((a >= 12'hB02 && a <= 12'hB1F) || (a >= 12'hB82 && a <= 12'hB9F)) c = ACC_RW;
    return c;
  endfunction
endpackage

// File: rtl/csr_perm_decode.sv
module csr_perm_decode
  import csr_guard_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic          dbg,
  output logic          illegal
);
  acc_class_e cls;
  logic       bad;

  always_comb begin
    cls = classify(addr);
    unique case (cls)
      ACC_ABSENT: bad = 1'b1;
      ACC_RO:     bad = wr;
      ACC_DBG:    bad = !dbg;
      default:    bad = 1'b0;
    endcase
  end

  assign illegal = valid && (rd || wr) && bad;

  a_r1_id_write_traps: assert property (@(posedge clk) disable iff (rst)
    (valid && wr && addr >= 12'hF11 && addr <= 12'hF15) |-> illegal);
  a_r4_debug_mode_legal: assert property (@(posedge clk) disable iff (rst)
    (valid && dbg && addr >= 12'h7B0 && addr <= 12'h7B3) |-> !illegal);
  a_r9_idle_clean: assert property (@(posedge clk) disable iff (rst)
    (!valid || !(rd || wr)) |-> !illegal);
endmodule

// File: rtl/csr_trap_regs.sv
module csr_trap_regs
  import csr_guard_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW = 12,
  parameter logic [XLEN-1:0] HART_ID = 5,
  parameter logic [XLEN-1:0] CAUSE_ILLEGAL = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid,
  input  logic            illegal,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [XLEN-1:0] wdata,
  input  logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] rdata,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] epc_q
);
  localparam int NSCR = 5;
  localparam logic [NSCR*AW-1:0] SCR_ADDRS =
    {A_DSCR1, A_DSCR0, A_IRQ_EN, A_MSCRATCH, A_MTVEC};

  logic [XLEN-1:0] scr_q [NSCR];
  logic            wr_ok;

  assign wr_ok = valid && wr && !illegal;

  for (genvar i = 0; i < NSCR; i++) begin : g_scr
    always_ff @(posedge clk) begin
      if (rst) scr_q[i] <= '0;
      else if (wr_ok && addr == SCR_ADDRS[i*AW +: AW]) scr_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      epc_q   <= '0;
    end else if (valid && illegal) begin
      cause_q <= CAUSE_ILLEGAL;
      epc_q   <= pc;
    end else begin
      if (wr_ok && addr == A_MCAUSE) cause_q <= wdata;
      if (wr_ok && addr == A_MEPC)   epc_q   <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_HARTID) rdata = HART_ID;
    if (addr == A_MCAUSE) rdata = cause_q;
    if (addr == A_MEPC)   rdata = epc_q;
    for (int i = 0; i < NSCR; i++)
      if (addr == SCR_ADDRS[i*AW +: AW]) rdata = scr_q[i];
  end

  a_r8_cause_set: assert property (@(posedge clk) disable iff (rst)
    (valid && illegal) |=> cause_q == CAUSE_ILLEGAL);
  a_r8_epc_capture: assert property (@(posedge clk) disable iff (rst)
    (valid && illegal) |=> epc_q == $past(pc));
  a_r9_no_side_effect: assert property (@(posedge clk) disable iff (rst)
    (valid && illegal) |=> ($stable(scr_q[0]) && $stable(scr_q[1]) && $stable(scr_q[2]) &&
                            $stable(scr_q[3]) && $stable(scr_q[4])));
endmodule

// File: rtl/csr_guard.sv
module csr_guard
  import csr_guard_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW = 12,
  parameter logic [XLEN-1:0] HART_ID = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ins_valid,
  input  logic [AW-1:0]   csr_addr,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic            dbg_mode,
  input  logic [XLEN-1:0] ins_pc,
  input  logic [XLEN-1:0] wr_data,
  output logic            illegal,
  output logic [XLEN-1:0] rd_data,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] epc_q
);
  logic            s_valid, s_rd, s_wr, s_dbg;
  logic [AW-1:0]   s_addr;
  logic [XLEN-1:0] s_pc, s_wdata, raw_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
      s_rd    <= 1'b0;
      s_wr    <= 1'b0;
      s_dbg   <= 1'b0;
      s_addr  <= '0;
      s_pc    <= '0;
      s_wdata <= '0;
    end else begin
      s_valid <= ins_valid;
      s_rd    <= ins_valid && rd_en;
      s_wr    <= ins_valid && wr_en;
      s_dbg   <= dbg_mode;
      s_addr  <= csr_addr;
      s_pc    <= ins_pc;
      s_wdata <= wr_data;
    end
  end

  csr_perm_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst(rst), .valid(s_valid), .addr(s_addr),
    .rd(s_rd), .wr(s_wr), .dbg(s_dbg), .illegal(illegal)
  );

  csr_trap_regs #(.XLEN(XLEN), .AW(AW), .HART_ID(HART_ID)) u_regs (
    .clk(clk), .rst(rst), .valid(s_valid), .illegal(illegal), .wr(s_wr),
    .addr(s_addr), .wdata(s_wdata), .pc(s_pc), .rdata(raw_rdata),
    .cause_q(cause_q), .epc_q(epc_q)
  );

  assign rd_data = (s_valid && s_rd && !illegal) ? raw_rdata : '0;

  a_r10_reset_quiet: assert property (@(posedge clk) rst |=> (!illegal && cause_q == '0 && epc_q == '0));
endmodule

// File: tb/sim_csr_guard.sv
module sim_csr_guard;
  typedef struct packed {
    logic [11:0] addr;
    logic        rd;
    logic        wr;
    logic        dbg;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{12'hF11,1,0,0,0,1}, '{12'hF11,0,1,0,1,1}, '{12'hF15,0,1,0,1,1},   // R1
    '{12'hF14,1,0,0,0,1},                                               // R1
    '{12'h302,1,0,0,1,2}, '{12'h303,0,1,0,1,2},                         // R2
    '{12'h7A0,1,0,0,0,3}, '{12'h7A0,0,1,0,1,3}, '{12'h7A1,1,0,0,1,3},   // R3
    '{12'h7B0,1,0,0,1,4}, '{12'h7B1,0,1,1,0,4}, '{12'hBFF,1,0,0,1,4},   // R4
    '{12'hBFF,0,1,1,0,4},                                               // R4
    '{12'hFE0,1,0,0,0,5}, '{12'hFE0,0,1,0,1,5}, '{12'hFE4,0,1,0,1,5},   // R5
    '{12'hBE0,0,1,0,0,5},                                               // R5
    '{12'h300,1,1,0,0,6}, '{12'h310,0,1,0,0,6}, '{12'h320,0,1,0,0,6},   // R6
    '{12'h323,0,1,0,0,6}, '{12'hB1F,0,1,0,0,6}, '{12'hB9F,0,1,0,0,6},   // R6
    '{12'h344,0,1,0,0,6},                                               // R6
    '{12'h123,1,0,0,1,7}, '{12'h7A2,1,0,0,1,7}, '{12'hB01,0,1,0,1,7}    // R7
  };

  logic        clk = 0, rst = 1;
  logic        ins_valid = 0, rd_en = 0, wr_en = 0, dbg_mode = 0;
  logic [11:0] csr_addr = '0;
  logic [31:0] ins_pc = '0, wr_data = '0;
  logic        illegal;
  logic [31:0] rd_data, cause_q, epc_q;
  int errors = 0, checks = 0;
  logic        got_ill;
  logic [31:0] got_rd;

  always #4 clk = ~clk;

  csr_guard u0 (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .csr_addr(csr_addr),
    .rd_en(rd_en), .wr_en(wr_en), .dbg_mode(dbg_mode), .ins_pc(ins_pc),
    .wr_data(wr_data), .illegal(illegal), .rd_data(rd_data),
    .cause_q(cause_q), .epc_q(epc_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive on a falling edge; sample flag and read data one falling edge later.
  task automatic issue(input logic [11:0] a, input logic r, input logic w, input logic d,
                       input logic [31:0] pc, input logic [31:0] wd, input logic v = 1);
    ins_valid = v; csr_addr = a; rd_en = r; wr_en = w; dbg_mode = d;
    ins_pc = pc; wr_data = wd;
    @(negedge clk);
    got_ill = illegal; got_rd = rd_data;
    ins_valid = 0; rd_en = 0; wr_en = 0;
    @(negedge clk);
  endtask

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 illegal", {31'b0, illegal}, 0);
    chk("R10 rd_data", rd_data, 0);
    chk("R10 cause", cause_q, 0);
    chk("R10 epc", epc_q, 0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].addr, VECS[i].rd, VECS[i].wr, VECS[i].dbg, 32'h1000 + 4*i, 32'h0);
      checks++;
      if (got_ill !== VECS[i].ill) begin
        errors++;
        $display("FAIL R%0d table addr=%h actual=%b expected=%b",
                 VECS[i].req, VECS[i].addr, got_ill, VECS[i].ill);
      end
    end

    // R1 hart id read value
    issue(12'hF14, 1, 0, 0, 32'h0, 32'h0);
    chk("R1 hartid", got_rd, 32'h5);

    // R8 cause and PC capture on a trapping write
    issue(12'h342, 0, 1, 0, 32'h0, 32'h0);
    chk("R6 cause cleared", cause_q, 0);
    issue(12'hFE0, 0, 1, 0, 32'h0000_2468, 32'hFFFF_FFFF);
    chk("R8 cause", cause_q, 2);
    chk("R8 epc", epc_q, 32'h0000_2468);

    // R6 persistence of legal writes
    issue(12'h340, 0, 1, 0, 32'h0, 32'hA5A5_0001);
    issue(12'h340, 1, 0, 0, 32'h0, 32'h0);
    chk("R6 mscratch", got_rd, 32'hA5A5_0001);
    issue(12'h305, 0, 1, 0, 32'h0, 32'h0000_0100);
    issue(12'h305, 1, 0, 0, 32'h0, 32'h0);
    chk("R6 mtvec", got_rd, 32'h0000_0100);
    issue(12'h341, 0, 1, 0, 32'h0, 32'h0000_0800);
    chk("R6 mepc", epc_q, 32'h0000_0800);

    // R5 interrupt-enable array persists; status array write traps
    issue(12'hBE0, 0, 1, 0, 32'h0, 32'h0000_00F3);
    issue(12'hBE0, 1, 0, 0, 32'h0, 32'h0);
    chk("R5 irq enable", got_rd, 32'h0000_00F3);

    // R4 / R9 debug scratch: trapped write outside debug mode leaves it unchanged
    issue(12'h7B2, 0, 1, 1, 32'h0, 32'h1357_9BDF);
    issue(12'h7B2, 0, 1, 0, 32'h0000_3000, 32'hDEAD_BEEF);
    chk("R4 trap out of debug", {31'b0, got_ill}, 1);
    chk("R8 epc debug", epc_q, 32'h0000_3000);
    issue(12'h7B2, 1, 0, 1, 32'h0, 32'h0);
    chk("R9 dscratch kept", got_rd, 32'h1357_9BDF);
    chk("R4 legal in debug", {31'b0, got_ill}, 0);

    // R9 trapped mscratch-region attempt via illegal address keeps mscratch
    issue(12'h7A1, 0, 1, 0, 32'h0, 32'h0);
    issue(12'h340, 1, 0, 0, 32'h0, 32'h0);
    chk("R9 mscratch kept", got_rd, 32'hA5A5_0001);

    // R9 strobes with no valid, and valid with no strobe
    issue(12'h303, 1, 1, 0, 32'h0, 32'h0, 0);
    chk("R9 no valid", {31'b0, got_ill}, 0);
    issue(12'h303, 0, 0, 0, 32'h0, 32'h0);
    chk("R9 no strobe", {31'b0, got_ill}, 0);
    // R3 trapping read of illegal returns zero data
    issue(12'h7A1, 1, 0, 0, 32'h0, 32'h0);
    chk("R3 read data zero", got_rd, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule